// File: doc/BRIEF.md
# Edge-Triggered Interrupt Flag Register

This block captures interrupt requests from a group of external pins. Each pin passes through a synchronizer and then an edge detector. A per-pin polarity input chooses whether a rising or a falling transition counts as an event. A detected event sets that pin's flag. The flag stays set until software clears it. Servicing the interrupt never clears a flag on its own.

A second, mostly empty register holds one flag for a serial-transfer-complete event. Both registers sit on a single-cycle write bus made of address, write strobe and write data. In both registers a written 0 clears a flag and a written 1 leaves it unchanged, so software can only clear flags and can never set them. Reads are combinational. The block also drives a single interrupt request, which is the OR of every pin flag qualified by its enable bit.

Top module: `irqf_ext_flags`

## Requirements
- R1: A pin transition becomes visible on its flag after the third rising clock edge that follows the change, counting the first edge that samples the new level. The flag does not show the event before that edge.
- R2: Polarity input bit n selects the active edge of pin n: 1 means rising and 0 means falling. A transition in the other direction leaves the flag unchanged.
- R3: A write to address 0 clears every pin flag n whose write-data bit n is 0. Pin flags whose write-data bit is 1 keep their value, so a write can never set a flag.
- R4: With no clearing write, a set flag stays set for any number of cycles, whatever the enables and the interrupt output do.
- R5: While reset is high, all pin flags and the serial flag are 0 (address 0 reads 0x00) and the interrupt output is 0.
- R6: When an event for a flag and a clearing write of 0 to that same flag land on the same clock edge, the flag ends up set. This applies to pin flags and to the serial flag.
- R7: The serial flag sits at bit 4 of address 1. It is set on the clock edge that samples a high serial-done input, and it is cleared only by writing 0 to bit 4 of address 1.
- R8: Bits 7 to 5 and 3 to 0 of address 1 always read 0, and writes to them have no effect. Addresses 2 and 3 read 0x00.
- R9: The interrupt output equals the OR over n of (pin flag n AND enable n). It follows the flags and the enable input combinationally.
- R10: The read data follows the address input combinationally, within the same cycle and with no clock edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_i | input | NUM_PINS | Asynchronous external interrupt pins |
| edge_pol_i | input | NUM_PINS | Active-edge select per pin (1 rising, 0 falling) |
| irq_en_i | input | NUM_PINS | Per-flag enable for the interrupt output |
| ser_done_i | input | 1 | Serial transfer complete pulse (synchronous) |
| bus_addr_i | input | 2 | Register address |
| bus_we_i | input | 1 | Write strobe |
| bus_wdata_i | input | 8 | Write data (0 bits clear flags) |
| bus_rdata_o | output | 8 | Combinational read data |
| ext_flags_o | output | NUM_PINS | Pin flag vector |
| irq_o | output | 1 | Combined enabled interrupt request |

## Verification
Each result has a known due time:
- A pin change appears on its flag at the third edge after the change.
- A serial-done pulse or a bus write takes effect at the next edge.
- Read data and the interrupt output respond within the same cycle.

The bench drives inputs just after a falling edge. It keeps a reference model that advances on each rising edge with a three-sample pin history, and it compares the outputs at the next falling edge. The directed cases check the flag after the first, second and third edges to pin down the latency. They check the combinational outputs a short delay after changing an input, with no clock edge in between.

// File: rtl/irqf_pkg.sv
package irqf_pkg;

    localparam int REG_W   = 8;
    localparam int BUS_AW  = 2;
    localparam int SER_BIT = 4;

    localparam logic [BUS_AW-1:0] ADDR_EXT = 2'd0;
    localparam logic [BUS_AW-1:0] ADDR_SER = 2'd1;

    typedef enum logic {
        EDGE_FALL = 1'b0,
        EDGE_RISE = 1'b1
    } edge_sel_e;

    typedef struct packed {
        logic              we;
        logic [BUS_AW-1:0] addr;
        logic [REG_W-1:0]  data;
    } bus_wr_t;

    // True when the sampled pair (older, newer) forms the selected transition.
    function automatic logic edge_seen(edge_sel_e sel, logic newer, logic older);
        logic hit;
        case (sel)
            EDGE_RISE: hit = newer & ~older;
            default:   hit = ~newer & older;
        endcase
        return hit;
    endfunction

    // Clear-by-zero write followed by event set; the set has priority.
    function automatic logic [REG_W-1:0] clear_then_set(
        logic [REG_W-1:0] cur, logic do_clear,
        logic [REG_W-1:0] keep_mask, logic [REG_W-1:0] set_mask);
        logic [REG_W-1:0] nxt;
        nxt = do_clear ? (cur & keep_mask) : cur;
        return nxt | set_mask;
    endfunction

endpackage

// File: rtl/irqf_edge_det.sv
module irqf_edge_det
    import irqf_pkg::*;
#(
    parameter int SYNC_STAGES = 2
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      pin_i,
    input  edge_sel_e sel_i,
    output logic      hit_o
);
    localparam int TOP = SYNC_STAGES - 1;

    logic [SYNC_STAGES-1:0] sync_q;
    logic                   prev_q;

    generate
        for (genvar s = 0; s < SYNC_STAGES; s++) begin : g_stage
            if (s == 0) begin : g_first
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= pin_i;
                end
            end else begin : g_next
                always_ff @(posedge clk) begin
                    if (rst) sync_q[s] <= 1'b0;
                    else     sync_q[s] <= sync_q[s-1];
                end
            end
        end
    endgenerate

    always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= sync_q[TOP];
    end

    assign hit_o = edge_seen(sel_i, sync_q[TOP], prev_q);

endmodule

// File: rtl/irqf_flag_bank.sv
module irqf_flag_bank
    import irqf_pkg::*;
#(
    parameter int WIDTH = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] set_i,
    input  logic             clr_wr_i,
    input  logic [WIDTH-1:0] keep_i,
    output logic [WIDTH-1:0] flags_o
);
    logic [WIDTH-1:0] flags_q;
    logic [REG_W-1:0] cur_w, keep_w, set_w, nxt_w;

    always_comb begin
        cur_w  = '0;
        keep_w = '0;
        set_w  = '0;
        for (int i = 0; i < WIDTH; i++) begin
            cur_w[i]  = flags_q[i];
            keep_w[i] = keep_i[i];
            set_w[i]  = set_i[i];
        end
        nxt_w = clear_then_set(cur_w, clr_wr_i, keep_w, set_w);
    end

    always_ff @(posedge clk) begin
        if (rst) flags_q <= '0;
        else     flags_q <= nxt_w[WIDTH-1:0];
    end

    assign flags_o = flags_q;

endmodule

// File: rtl/irqf_read_mux.sv
module irqf_read_mux
    import irqf_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input  logic [BUS_AW-1:0]   addr_i,
    input  logic [NUM_PINS-1:0] ext_flags_i,
    input  logic                ser_flag_i,
    output logic [REG_W-1:0]    rdata_o
);
    always_comb begin
        rdata_o = '0;
        case (addr_i)
            ADDR_EXT: begin
                for (int i = 0; i < NUM_PINS; i++) rdata_o[i] = ext_flags_i[i];
            end
            ADDR_SER: rdata_o[SER_BIT] = ser_flag_i;
            default:  rdata_o = '0;
        endcase
    end

endmodule

// File: rtl/irqf_ext_flags.sv
module irqf_ext_flags
    import irqf_pkg::*;
#(
    parameter int NUM_PINS    = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic [NUM_PINS-1:0] pin_i,
    input  logic [NUM_PINS-1:0] edge_pol_i,
    input  logic [NUM_PINS-1:0] irq_en_i,
    input  logic                ser_done_i,
    input  logic [BUS_AW-1:0]   bus_addr_i,
    input  logic                bus_we_i,
    input  logic [REG_W-1:0]    bus_wdata_i,
    output logic [REG_W-1:0]    bus_rdata_o,
    output logic [NUM_PINS-1:0] ext_flags_o,
    output logic                irq_o
);
    bus_wr_t             wr;
    logic                ext_clr;
    logic                ser_clr;
    logic [NUM_PINS-1:0] edge_hit;
    logic [NUM_PINS-1:0] ext_keep;
    logic [0:0]          ser_flag;

    assign wr      = '{we: bus_we_i, addr: bus_addr_i, data: bus_wdata_i};
    assign ext_clr = wr.we && (wr.addr == ADDR_EXT);
    assign ser_clr = wr.we && (wr.addr == ADDR_SER);
    assign ext_keep = wr.data[NUM_PINS-1:0];

    generate
        for (genvar n = 0; n < NUM_PINS; n++) begin : g_pin
            irqf_edge_det #(
                .SYNC_STAGES(SYNC_STAGES)
            ) det_i (
                .clk  (clk),
                .rst  (rst),
                .pin_i(pin_i[n]),
                .sel_i(edge_sel_e'(edge_pol_i[n])),
                .hit_o(edge_hit[n])
            );
        end
    endgenerate

    irqf_flag_bank #(
        .WIDTH(NUM_PINS)
    ) ext_bank_i (
        .clk     (clk),
        .rst     (rst),
        .set_i   (edge_hit),
        .clr_wr_i(ext_clr),
        .keep_i  (ext_keep),
        .flags_o (ext_flags_o)
    );

    irqf_flag_bank #(
        .WIDTH(1)
    ) ser_bank_i (
        .clk     (clk),
        .rst     (rst),
        .set_i   (ser_done_i),
        .clr_wr_i(ser_clr),
        .keep_i  (wr.data[SER_BIT]),
        .flags_o (ser_flag)
    );

    irqf_read_mux #(
        .NUM_PINS(NUM_PINS)
    ) rmux_i (
        .addr_i     (bus_addr_i),
        .ext_flags_i(ext_flags_o),
        .ser_flag_i (ser_flag[0]),
        .rdata_o    (bus_rdata_o)
    );

    assign irq_o = |(ext_flags_o & irq_en_i);

endmodule

// File: rtl/irqf_ext_flags_chk.sv
module irqf_ext_flags_chk
    import irqf_pkg::*;
#(
    parameter int NUM_PINS = 8
) (
    input logic                clk,
    input logic                rst,
    input logic [NUM_PINS-1:0] edge_hit,
    input logic [NUM_PINS-1:0] ext_flags,
    input logic [NUM_PINS-1:0] irq_en,
    input logic                ser_done,
    input logic                ser_flag,
    input logic [BUS_AW-1:0]   bus_addr,
    input logic                bus_we,
    input logic [REG_W-1:0]    bus_wdata,
    input logic [REG_W-1:0]    bus_rdata,
    input logic                irq
);
    logic ext_wr;
    logic ser_wr;
    assign ext_wr = bus_we && (bus_addr == ADDR_EXT);
    assign ser_wr = bus_we && (bus_addr == ADDR_SER);

    generate
        for (genvar i = 0; i < NUM_PINS; i++) begin : g_bit
            // R1: a detected edge shows on the flag at the next edge
            p_edge_sets_r1: assert property (@(posedge clk) disable iff (rst)
                edge_hit[i] |=> ext_flags[i]);
            // R3: a flag never rises without a detected edge
            p_no_sw_set_r3: assert property (@(posedge clk) disable iff (rst)
                (!edge_hit[i] && !ext_flags[i]) |=> !ext_flags[i]);
            // R4: a flag falls only after a clearing write of 0
            p_hold_r4: assert property (@(posedge clk) disable iff (rst)
                (ext_flags[i] && !(ext_wr && !bus_wdata[i])) |=> ext_flags[i]);
            // R6: set wins over a same-edge clear
            p_set_wins_r6: assert property (@(posedge clk) disable iff (rst)
                (edge_hit[i] && ext_wr && !bus_wdata[i]) |=> ext_flags[i]);
        end
    endgenerate

    // R7: serial-done pulse sets the serial flag
    p_ser_set_r7: assert property (@(posedge clk) disable iff (rst)
        ser_done |=> ser_flag);

    // R7: serial flag falls only after a write of 0 to its bit
    p_ser_hold_r7: assert property (@(posedge clk) disable iff (rst)
        (ser_flag && !(ser_wr && !bus_wdata[SER_BIT])) |=> ser_flag);

    // R8: reserved bits of the serial register read zero
    p_reserved_zero_r8: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == ADDR_SER) |-> ((bus_rdata & ~(8'(1) << SER_BIT)) == '0));

    // R9: request output tracks the enabled flags
    p_irq_match_r9: assert property (@(posedge clk) disable iff (rst)
        irq == |(ext_flags & irq_en));

endmodule

bind irqf_ext_flags irqf_ext_flags_chk #(
    .NUM_PINS(NUM_PINS)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .edge_hit (edge_hit),
    .ext_flags(ext_flags_o),
    .irq_en   (irq_en_i),
    .ser_done (ser_done_i),
    .ser_flag (ser_flag[0]),
    .bus_addr (bus_addr_i),
    .bus_we   (bus_we_i),
    .bus_wdata(bus_wdata_i),
    .bus_rdata(bus_rdata_o),
    .irq      (irq_o)
);

// File: tb/irqf_ext_flags_tb_top.sv
`timescale 1ns/1ps
module irqf_ext_flags_tb_top;

    localparam int NP = 8;

    logic          clk = 1'b0;
    logic          rst;
    logic [NP-1:0] pin_d, pol_d, en_d;
    logic          ser_d;
    logic [1:0]    addr_d;
    logic          we_d;
    logic [7:0]    wdata_d;
    logic [7:0]    rdata;
    logic [NP-1:0] flags;
    logic          irq;

    int n_chk  = 0;
    int n_fail = 0;
    bit done   = 0;

    always #10 clk = ~clk;

    irqf_ext_flags #(.NUM_PINS(NP), .SYNC_STAGES(2)) dut_i (
        .clk        (clk),
        .rst        (rst),
        .pin_i      (pin_d),
        .edge_pol_i (pol_d),
        .irq_en_i   (en_d),
        .ser_done_i (ser_d),
        .bus_addr_i (addr_d),
        .bus_we_i   (we_d),
        .bus_wdata_i(wdata_d),
        .bus_rdata_o(rdata),
        .ext_flags_o(flags),
        .irq_o      (irq)
    );

    // Reference model: pin samples at the last three edges.
    logic [NP-1:0] p1, p2, p3, m_ext;
    logic          m_ser;

    always @(posedge clk) begin
        logic [NP-1:0] hit;
        if (rst) begin
            p1 = '0; p2 = '0; p3 = '0; m_ext = '0; m_ser = 1'b0;
        end else begin
            hit = (pol_d & p2 & ~p3) | (~pol_d & ~p2 & p3);
            if (we_d && addr_d == 2'd0) m_ext = m_ext & wdata_d;
            m_ext = m_ext | hit;
            if (we_d && addr_d == 2'd1 && !wdata_d[4]) m_ser = 1'b0;
            if (ser_d) m_ser = 1'b1;
            p3 = p2; p2 = p1; p1 = pin_d;
        end
    end

    function automatic logic [7:0] exp_rd(logic [1:0] a, logic [NP-1:0] e, logic s);
        case (a)
            2'd0:    return e;
            2'd1:    return {3'b000, s, 4'b0000};
            default: return 8'h00;
        endcase
    endfunction

    task automatic check(string tag, logic [7:0] act, logic [7:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        @(negedge clk);
    endtask

    task automatic wr(logic [1:0] a, logic [7:0] d);
        addr_d = a; we_d = 1'b1; wdata_d = d;
        tick();
        we_d = 1'b0;
    endtask

    task automatic rd_now(logic [1:0] a);
        addr_d = a;
        #1;
    endtask

    initial begin
        rst = 1'b1; pin_d = '0; pol_d = '1; en_d = '0; ser_d = 1'b0;
        addr_d = 2'd0; we_d = 1'b0; wdata_d = '0;
        repeat (3) tick();
        check("R5 flags in reset", flags, 8'h00);
        check("R5 irq in reset", {7'd0, irq}, 8'h00);
        rst = 1'b0;
        tick();
        en_d = '1;
        rd_now(2'd0);
        check("R5 addr0 after reset", rdata, 8'h00);
        check("R5 irq after reset", {7'd0, irq}, 8'h00);
        rd_now(2'd1);
        check("R5 addr1 after reset", rdata, 8'h00);
        en_d = '0;

        // R1 latency, rising edge on pin 0
        pin_d[0] = 1'b1;
        tick(); check("R1 after edge 1", flags, 8'h00);
        tick(); check("R1 after edge 2", flags, 8'h00);
        tick(); check("R1 after edge 3", flags, 8'h01);

        // R2 falling polarity on pin 1
        pol_d[1] = 1'b0;
        tick();
        pin_d[1] = 1'b1;
        repeat (4) tick();
        check("R2 wrong direction ignored", flags, 8'h01);
        pin_d[1] = 1'b0;
        repeat (4) tick();
        check("R2 falling edge sets", flags, 8'h03);

        // R3 write ones has no effect, write zero clears
        wr(2'd0, 8'hFF);
        check("R3 write ones", flags, 8'h03);
        wr(2'd0, 8'hFE);
        check("R3 write zero clears bit0", flags, 8'h02);

        // R4 held without clear
        en_d = '1;
        repeat (20) tick();
        check("R4 flags held", flags, 8'h02);
        check("R4 irq held", {7'd0, irq}, 8'h01);

        // R6 collision: edge on pin 2 lands with a clear-all write
        pin_d[2] = 1'b1;
        tick(); tick();
        wr(2'd0, 8'h00);
        check("R6 set wins on pin", flags, 8'h04);

        // R7 serial flag
        ser_d = 1'b1; tick(); ser_d = 1'b0;
        rd_now(2'd1);
        check("R7 serial set", rdata, 8'h10);
        wr(2'd1, 8'hFF);
        rd_now(2'd1);
        check("R7 write one no effect", rdata, 8'h10);
        ser_d = 1'b1;
        wr(2'd1, 8'h00);
        ser_d = 1'b0;
        rd_now(2'd1);
        check("R6 set wins on serial", rdata, 8'h10);
        wr(2'd1, 8'hEF);
        rd_now(2'd1);
        check("R7 serial cleared", rdata, 8'h00);

        // R8 reserved bits and unmapped addresses
        wr(2'd1, 8'hFF);
        rd_now(2'd1);
        check("R8 reserved bits read 0", rdata, 8'h00);
        rd_now(2'd2);
        check("R8 addr2 reads 0", rdata, 8'h00);
        rd_now(2'd3);
        check("R8 addr3 reads 0", rdata, 8'h00);

        // R9 enable masking
        en_d = 8'hFB; #1;
        check("R9 masked", {7'd0, irq}, 8'h00);
        en_d = 8'h04; #1;
        check("R9 enabled", {7'd0, irq}, 8'h01);

        // R10 combinational read
        rd_now(2'd0);
        check("R10 read addr0", rdata, 8'h04);
        rd_now(2'd1);
        check("R10 read addr1", rdata, 8'h00);

        // Random phase against the model
        void'($urandom(32'd2718));
        for (int c = 0; c < 3000; c++) begin
            for (int b = 0; b < NP; b++)
                if ($urandom_range(7) == 0) pin_d[b] = ~pin_d[b];
            if ($urandom_range(63) == 0) pol_d = NP'($urandom);
            en_d    = NP'($urandom);
            ser_d   = ($urandom_range(15) == 0);
            we_d    = ($urandom_range(3) == 0);
            addr_d  = 2'($urandom);
            wdata_d = 8'($urandom);
            tick();
            check("R4 flag vector", flags, m_ext);
            check("R10 read data", rdata, exp_rd(addr_d, m_ext, m_ser));
            check("R9 irq", {7'd0, irq}, {7'd0, |(m_ext & en_d)});
        end

        done = 1;
        $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
            $finish;
        end
    end

endmodule